// File: doc/BRIEF.md
# Byte-Parallel Configuration Loader with Serial Forwarding

This block receives configuration data for a programmable device over an 8-bit bus. The bus is timed by an external configuration clock, and that same clock runs the block. While the mode pins select the synchronous byte-loading mode and the enable input is high, the loader takes one byte on every eighth rising edge. It marks each accepted byte with a one-cycle acknowledge pulse. It then turns the byte into a serial bit stream, one bit per rising edge.

The stream is split by bit position. A leading preamble of `PRE_BITS` bits is passed on, and so is every bit after the lead device's own share of `LEAD_BITS` bits. The passed-on bits go out on a serial output that changes on the falling clock edge, so the next device in a daisy chain can sample it on the following rising edge. The lead device keeps its own share, and the serial output rests high while those bits go by. Once the lead share is complete, the loader counts a fixed flush of ten rising edges plus one per chained device, and then raises a sticky done flag.

Top module: `cfg_loader`

## Requirements
- R1: The loader is active only while `mode_i` equals 3'b011, `load_en_i` is high and `rst_i` is low. In any other state it captures no data, and its bit and flush counters hold.
- R2: The first active rising edge captures `data_i` as byte 0. Byte k is captured on the rising edge 8·k edges after that first one. Data on the bus at any other edge is ignored.
- R3: While active, `ack_o` is high for exactly the one clock period that follows each capturing edge. It is low for the other seven periods.
- R4: While the loader is not active (including before the enable rises), `ack_o` reads high.
- R5: Each byte is serialized most-significant bit first, one bit per rising edge. Stream bit n (counting from 0) is bit 7 − (n mod 8) of byte n/8.
- R6: Stream bits with index n < `PRE_BITS`, and bits with n ≥ `PRE_BITS`+`LEAD_BITS`, are forwarded on `ser_o`. The bits in between are consumed by the lead device, and `ser_o` is high while they pass.
- R7: Stream bit n is placed on `ser_o` at the falling edge that follows rising edge n+1, counting the first capturing edge as edge 0. It stays there through rising edge n+2.
- R8: `done_o` goes high after rising edge `PRE_BITS`+`LEAD_BITS`+10+`CHAIN_LEN` (edge 36 with the defaults). It is low before that edge and stays high until reset.
- R9: A synchronous reset returns the byte phase to the first-byte state and clears the bit and flush counts. It also drives `ack_o` and `ser_o` high and `done_o` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | External configuration clock |
| rst_i | input | 1 | Synchronous reset, active high |
| mode_i | input | 3 | Mode select pins; 3'b011 selects this mode |
| load_en_i | input | 1 | Loading enable, high once initialization is released |
| data_i | input | 8 | Parallel configuration byte |
| ack_o | output | 1 | Byte acknowledge pulse, idles high |
| ser_o | output | 1 | Serial forward output to the next device, changes on falling edge |
| done_o | output | 1 | Sticky completion flag |

## Verification
A full stream of seven bytes with distinct bit patterns is sent, and each forwarded bit is checked against its position. This separates MSB-first from LSB-first order, shows where the preamble ends and where forwarding resumes, and shows whether the output lags by the required edge count. The bytes on the bus between accept edges are the bitwise inverse of the real data, so a design that samples on the wrong edge gives wrong bits. Wrong mode values, and a correct mode with the enable low, are applied while the bus toggles, to confirm that nothing is captured or acknowledged. A reset in the middle of a stream, followed by a new stream with a different pattern, shows that the byte phase and bit count restart from the first byte.

// File: rtl/cfgload_pkg.sv
package cfgload_pkg;
   localparam logic [2:0] SYNC_BYTE_MODE = 3'b011;

   typedef enum logic {
      ORDER_MSB_FIRST = 1'b0,
      ORDER_LSB_FIRST = 1'b1
   } bit_order_e;
endpackage

// File: rtl/cfg_byte_phase.sv
module cfg_byte_phase #(
   parameter int BYTE_W = 8
) (
   input  logic                       clk_i,
   input  logic                       rst_i,
   input  logic                       active_i,
   output logic                       accept_o,
   output logic                       ack_o,
   output logic [$clog2(BYTE_W)-1:0]  phase_o
);
   localparam int PH_W = $clog2(BYTE_W);
   localparam logic [PH_W-1:0] PH_LAST = PH_W'(BYTE_W - 1);

   logic [PH_W-1:0] phase_q;
   logic            ack_q;

   assign accept_o = active_i && (phase_q == '0);

   always_ff @(posedge clk_i) begin
      if (rst_i || !active_i) begin
         phase_q <= '0;
         ack_q   <= 1'b1;
      end else begin
         phase_q <= (phase_q == PH_LAST) ? '0 : phase_q + 1'b1;
         ack_q   <= (phase_q == '0);
      end
   end

   assign ack_o   = ack_q;
   assign phase_o = phase_q;

   // R4
   idle_ack_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      !active_i |=> ack_q);
endmodule

// File: rtl/cfg_shifter.sv
module cfg_shifter
   import cfgload_pkg::*;
#(
   parameter int         BYTE_W = 8,
   parameter bit_order_e ORDER  = ORDER_MSB_FIRST
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic              active_i,
   input  logic              accept_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              bit_o,
   output logic              valid_o
);
   logic [BYTE_W-1:0] sreg_q;
   logic [BYTE_W-1:0] shifted;
   logic              valid_q;

   generate
      if (ORDER == ORDER_MSB_FIRST) begin : g_msb
         assign bit_o   = sreg_q[BYTE_W-1];
         assign shifted = {sreg_q[BYTE_W-2:0], 1'b0};
      end else begin : g_lsb
         assign bit_o   = sreg_q[0];
         assign shifted = {1'b0, sreg_q[BYTE_W-1:1]};
      end
   endgenerate

   always_ff @(posedge clk_i) begin
      if (rst_i || !active_i) begin
         valid_q <= 1'b0;
         sreg_q  <= '0;
      end else if (accept_i) begin
         valid_q <= 1'b1;
         sreg_q  <= data_i;
      end else begin
         sreg_q  <= shifted;
      end
   end

   assign valid_o = valid_q;
endmodule

// File: rtl/cfg_stream_ctrl.sv
module cfg_stream_ctrl #(
   parameter int PRE_BITS    = 8,
   parameter int LEAD_BITS   = 16,
   parameter int FLUSH_EDGES = 12
) (
   input  logic clk_i,
   input  logic rst_i,
   input  logic active_i,
   input  logic bit_valid_i,
   input  logic bit_i,
   output logic fwd_o,
   output logic lead_full_o,
   output logic done_o
);
   localparam int LEAD_END = PRE_BITS + LEAD_BITS;
   localparam int CNT_W    = $clog2(LEAD_END + 1);
   localparam int FL_W     = $clog2(FLUSH_EDGES + 1);
   localparam logic [CNT_W-1:0] CNT_PRE = CNT_W'(PRE_BITS);
   localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LEAD_END);
   localparam logic [FL_W-1:0]  FL_END  = FL_W'(FLUSH_EDGES);

   logic [CNT_W-1:0] bit_cnt_q;
   logic [FL_W-1:0]  flush_q;
   logic             fwd_q;
   logic             in_lead;
   logic             lead_full;

   assign lead_full = (bit_cnt_q == CNT_END);
   assign in_lead   = (bit_cnt_q >= CNT_PRE) && !lead_full;

   always_ff @(posedge clk_i) begin
      if (rst_i) begin
         bit_cnt_q <= '0;
         fwd_q     <= 1'b1;
      end else if (active_i && bit_valid_i) begin
         fwd_q <= in_lead ? 1'b1 : bit_i;
         if (!lead_full) bit_cnt_q <= bit_cnt_q + 1'b1;
      end else begin
         fwd_q <= 1'b1;
      end
   end

   always_ff @(posedge clk_i) begin
      if (rst_i)
         flush_q <= '0;
      else if (active_i && lead_full && (flush_q != FL_END))
         flush_q <= flush_q + 1'b1;
   end

   assign fwd_o       = fwd_q;
   assign lead_full_o = lead_full;
   assign done_o      = (flush_q == FL_END);

   // R8
   done_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |=> done_o);
   // R8
   done_after_lead_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      done_o |-> lead_full);
endmodule

// File: rtl/cfg_serial_out.sv
module cfg_serial_out (
   input  logic clk_i,
   input  logic rst_i,
   input  logic fwd_i,
   output logic ser_o
);
   logic ser_q;

   always_ff @(negedge clk_i) begin
      if (rst_i) ser_q <= 1'b1;
      else       ser_q <= fwd_i;
   end

   assign ser_o = ser_q;
endmodule

// File: rtl/cfg_loader.sv
module cfg_loader
   import cfgload_pkg::*;
#(
   parameter int         BYTE_W     = 8,
   parameter int         PRE_BITS   = 8,
   parameter int         LEAD_BITS  = 16,
   parameter int         FLUSH_BASE = 10,
   parameter int         CHAIN_LEN  = 2,
   parameter bit_order_e ORDER      = ORDER_MSB_FIRST
) (
   input  logic              clk_i,
   input  logic              rst_i,
   input  logic [2:0]        mode_i,
   input  logic              load_en_i,
   input  logic [BYTE_W-1:0] data_i,
   output logic              ack_o,
   output logic              ser_o,
   output logic              done_o
);
   localparam int FLUSH_EDGES = FLUSH_BASE + CHAIN_LEN;
   localparam int PH_W        = $clog2(BYTE_W);

   generate
      if (BYTE_W < 2 || (1 << PH_W) != BYTE_W) begin : g_bad_width
         $error("BYTE_W must be a power of two, at least 2");
      end
      if (LEAD_BITS < 1 || PRE_BITS < 0) begin : g_bad_split
         $error("LEAD_BITS must be positive and PRE_BITS non-negative");
      end
      if (CHAIN_LEN < 0 || FLUSH_BASE < 1) begin : g_bad_flush
         $error("flush length parameters out of range");
      end
   endgenerate

   logic            active;
   logic            accept;
   logic [PH_W-1:0] phase;
   logic            cur_bit;
   logic            bit_valid;
   logic            fwd;
   logic            lead_full;

   assign active = !rst_i && (mode_i == SYNC_BYTE_MODE) && load_en_i;

   cfg_byte_phase #(.BYTE_W(BYTE_W)) u_phase (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .active_i (active),
      .accept_o (accept),
      .ack_o    (ack_o),
      .phase_o  (phase)
   );

   cfg_shifter #(.BYTE_W(BYTE_W), .ORDER(ORDER)) u_shift (
      .clk_i    (clk_i),
      .rst_i    (rst_i),
      .active_i (active),
      .accept_i (accept),
      .data_i   (data_i),
      .bit_o    (cur_bit),
      .valid_o  (bit_valid)
   );

   cfg_stream_ctrl #(
      .PRE_BITS    (PRE_BITS),
      .LEAD_BITS   (LEAD_BITS),
      .FLUSH_EDGES (FLUSH_EDGES)
   ) u_stream (
      .clk_i       (clk_i),
      .rst_i       (rst_i),
      .active_i    (active),
      .bit_valid_i (bit_valid),
      .bit_i       (cur_bit),
      .fwd_o       (fwd),
      .lead_full_o (lead_full),
      .done_o      (done_o)
   );

   cfg_serial_out u_ser (
      .clk_i (clk_i),
      .rst_i (rst_i),
      .fwd_i (fwd),
      .ser_o (ser_o)
   );

   // R3
   ack_once_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (active && $past(active) && $past(active, 2) && $past(ack_o)) |-> !ack_o);
   // R2
   accept_phase_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (active && $past(active) && ack_o) |-> (phase == PH_W'(1)));
   // R1
   idle_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
      (!active && !lead_full) |=> $stable(lead_full));
endmodule

// File: tb/test_cfg_loader.sv
module test_cfg_loader;
   localparam int PRE_BITS  = 8;
   localparam int LEAD_BITS = 16;
   localparam int CHAIN_LEN = 2;
   localparam int LEAD_END  = PRE_BITS + LEAD_BITS;
   localparam int DONE_EDGE = LEAD_END + 10 + CHAIN_LEN;

   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic [2:0] mode = 3'b000;
   logic       en = 1'b0;
   logic [7:0] data = 8'h00;
   logic       ack, ser, done;

   int checks = 0;
   int errors = 0;

   always #5 clk = ~clk;

   cfg_loader #(
      .PRE_BITS  (PRE_BITS),
      .LEAD_BITS (LEAD_BITS),
      .CHAIN_LEN (CHAIN_LEN)
   ) i_cfg_loader (
      .clk_i     (clk),
      .rst_i     (rst),
      .mode_i    (mode),
      .load_en_i (en),
      .data_i    (data),
      .ack_o     (ack),
      .ser_o     (ser),
      .done_o    (done)
   );

   function automatic logic [7:0] pat(int seed, int idx);
      return 8'((seed * 29 + idx * 53) ^ (idx * 7 + 161));
   endfunction

   task automatic chk(string req, string what, logic act, logic exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
      end
   endtask

   task automatic do_reset();
      rst = 1'b1;
      en  = 1'b0;
      @(posedge clk); #2;
      chk("R9", "ack after reset", ack, 1'b1);
      chk("R9", "done after reset", done, 1'b0);
      @(negedge clk); #1;
      chk("R9", "ser after reset", ser, 1'b1);
      rst = 1'b0;
   endtask

   // R1 R4: no capture, ack idle high, ser high, no done
   task automatic run_idle(logic [2:0] m, logic e, int n);
      mode = m;
      en   = e;
      for (int i = 0; i < n; i++) begin
         data = pat(99, i);
         @(posedge clk); #2;
         chk("R4", "ack while idle", ack, 1'b1);
         chk("R1", "done while idle", done, 1'b0);
         @(negedge clk); #1;
         chk("R1", "ser while idle", ser, 1'b1);
      end
      en = 1'b0;
   endtask

   // R2 R3 R5 R6 R7 R8: full stream with edge-exact expectations
   task automatic run_stream(int seed, int nedges);
      logic [7:0] b;
      logic       exp_ser;
      int         n;
      mode = 3'b011;
      en   = 1'b1;
      for (int e = 0; e <= nedges; e++) begin
         b    = pat(seed, e / 8);
         data = (e % 8 == 0) ? b : ~b;
         @(posedge clk); #2;
         chk("R3", $sformatf("ack after edge %0d", e), ack, (e % 8 == 0));
         chk("R8", $sformatf("done after edge %0d", e), done, (e >= DONE_EDGE));
         @(negedge clk); #1;
         if (e >= 1) begin
            n = e - 1;
            b = pat(seed, n / 8);
            exp_ser = (n < PRE_BITS || n >= LEAD_END) ? b[7 - (n % 8)] : 1'b1;
            chk((n < PRE_BITS || n >= LEAD_END) ? "R5/R6/R7" : "R6",
                $sformatf("ser bit %0d", n), ser, exp_ser);
         end
      end
   endtask

   initial begin
      #2_000_000;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      @(negedge clk); #1;
      do_reset();
      run_idle(3'b010, 1'b1, 10);
      run_idle(3'b111, 1'b1, 6);
      run_idle(3'b011, 1'b0, 10);
      run_stream(1, 50);
      do_reset();
      run_stream(2, 20);
      do_reset();
      run_stream(3, 44);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule